// File: doc/BRIEF.md
# Subcode Q and R-W Channel Extractor

This block sits behind the frame demodulator of an optical-disc data path. Each frame delivers one 8-bit subcode symbol and a marker that flags the first sync frame of a 98-frame subcode block. The block follows block framing, separates the channels carried in each symbol and serves two host-facing paths.

The Q path collects one bit per data frame into a 96-bit word. When a block completes, that word is latched into a host-readable buffer together with a CRC verdict, and an interrupt flag is raised. The R-W path takes the six low bits of each data frame, joins them into a continuous bit stream, cuts that stream into bytes and queues the bytes in a bounded FIFO. The host drains the FIFO at its own pace.

Framing faults are handled without corrupting the host-visible Q buffer. A sync marker that arrives too early, or a block that runs too long, raises a sticky error flag. Framing then restarts at the next marker.

Top module: `subq_rw_extract`

## Requirements
- R1: After reset, q_irq, rw_ovf and sync_err are 0, rw_empty is 1, rw_count is 0, q_crc_ok is 0 and every Q byte reads 0.
- R2: A valid symbol with sym_sync high is frame 0 of a block. Frame 1 is skipped. Frames 2 to 97 are data frames. Valid symbols that arrive before the first sync marker are ignored.
- R3: Bit 6 of each data frame is a Q bit. The first Q bit becomes the MSB of Q byte 0. Q bytes 0 to 11 are read through q_byte_idx, and indices 12 to 15 read 0.
- R4: When a block is latched, q_crc_ok is 1 exactly when a CRC-16 over the first 80 Q bits equals the bitwise inverse of the last 16 Q bits. The CRC uses polynomial 0x1021, an initial value of 0 and MSB-first order.
- R5: Each completed block sets a pending flag, and q_irq equals that flag gated by q_irq_en. Clearing q_irq_en does not clear the pending flag. A q_clr pulse clears it.
- R6: Bits 5..0 of each data frame join an R-W bit stream in arrival order, with bit 5 first. The stream is cut MSB-first into bytes, giving 72 bytes per block. The packer restarts at each sync marker.
- R7: The R-W FIFO is first-in first-out. rw_data shows the oldest byte while rw_empty is 0, and an rw_pop pulse removes it. rw_count gives the number of bytes held.
- R8: When the FIFO holds RW_DEPTH bytes, new R-W bytes are dropped and the held contents stay unchanged. rw_ovf is then set and stays set until an rw_ovf_clr pulse.
- R9: A sync marker that arrives before frame 97 of the current block discards the partial Q word. The Q bytes and the pending flag are unchanged, sync_err is set, and a new block starts from that marker.
- R10: A non-sync symbol that arrives after frame 97 sets sync_err. All symbols after it are then ignored until the next sync marker.
- R11: sync_err is sticky and a sync_err_clr pulse clears it.
- R12: Bit 7 (P channel) of the symbols has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_valid | input | 1 | Subcode symbol strobe, one per frame |
| sym_data | input | 8 | Subcode symbol: P at bit 7, Q at bit 6, R..W at bits 5..0 |
| sym_sync | input | 1 | Marks the frame-0 sync symbol of a block |
| q_byte_idx | input | 4 | Q byte select, 0 to 11 |
| q_byte | output | 8 | Selected byte of the latched Q word |
| q_crc_ok | output | 1 | CRC verdict for the latched Q word |
| q_irq_en | input | 1 | Interrupt enable for the Q pending flag |
| q_irq | output | 1 | Q-ready interrupt |
| q_clr | input | 1 | Pulse to clear the Q pending flag |
| rw_pop | input | 1 | Pulse to remove the FIFO head |
| rw_data | output | 8 | FIFO head byte (0 when empty) |
| rw_empty | output | 1 | FIFO empty |
| rw_count | output | $clog2(RW_DEPTH+1) | Bytes held in the FIFO |
| rw_ovf | output | 1 | Sticky FIFO overflow flag |
| rw_ovf_clr | input | 1 | Pulse to clear rw_ovf |
| sync_err | output | 1 | Sticky framing-error flag |
| sync_err_clr | input | 1 | Pulse to clear sync_err |

## Verification
A wrong frame counter shows up in two ways. The Q bytes come out shifted, because a bit is gained or lost at a block edge, and the R-W byte count moves away from 72 per block. Both are visible right after the last data frame. A packer fault appears at the first R-W byte, because the bytes are compared one by one in the order they are popped. A wrong full or pointer state shows at the ports as a count other than RW_DEPTH, or as wrong bytes, on the first drain after an overflow. A framing-state error raises or withholds sync_err one cycle after the offending symbol.

// File: rtl/subq_pkg.sv
package subq_pkg;
  localparam int FRAMES     = 98;
  localparam int FIRST_DATA = 2;
  localparam int Q_BITS     = 96;
  localparam int Q_BYTES    = Q_BITS / 8;

  // CRC-16, poly 0x1021, init 0, MSB first, over 80 data bits
  function automatic logic [15:0] q_crc_calc(input logic [79:0] d);
    logic [15:0] c;
    logic fb;
    c = '0;
    for (int i = 79; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic q_crc_good(input logic [95:0] q);
    return q_crc_calc(q[95:16]) == ~q[15:0];
  endfunction

  // joined = {held bits, new 6 bits}; held valid count c >= 2 emits a byte
  function automatic logic [7:0] rw_take_byte(input logic [11:0] joined,
                                              input logic [2:0] c);
    return 8'(joined >> (c - 3'd2));
  endfunction
endpackage

// File: rtl/subq_framer.sv
module subq_framer import subq_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic sym_valid,
  input  logic sym_sync,
  output logic blk_start,
  output logic data_stb,
  output logic blk_done,
  output logic over_run,
  output logic sync_fault
);
  localparam int IW = $clog2(FRAMES + 1);
  localparam logic [IW-1:0] IDX_END  = IW'(FRAMES);
  localparam logic [IW-1:0] IDX_LAST = IW'(FRAMES - 1);
  localparam logic [IW-1:0] IDX_DAT  = IW'(FIRST_DATA);

  logic          locked;
  logic [IW-1:0] idx;
  logic          in_block;

  always_comb begin
    in_block   = locked && (idx < IDX_END);
    blk_start  = sym_valid && sym_sync;
    data_stb   = sym_valid && !sym_sync && in_block && (idx >= IDX_DAT);
    blk_done   = data_stb && (idx == IDX_LAST);
    over_run   = sym_valid && !sym_sync && locked && (idx == IDX_END);
    sync_fault = (blk_start && in_block) || over_run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      idx    <= '0;
    end else if (blk_start) begin
      locked <= 1'b1;
      idx    <= IW'(1);
    end else if (over_run) begin
      locked <= 1'b0;
    end else if (sym_valid && in_block) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/subq_qbuf.sv
module subq_qbuf import subq_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_stb,
  input  logic              blk_done,
  input  logic              q_bit,
  input  logic              q_clr,
  input  logic [3:0]        byte_idx,
  output logic [Q_BITS-1:0] q_buf,
  output logic [7:0]        q_byte,
  output logic              crc_ok,
  output logic              pending
);
  logic [Q_BITS-2:0] q_sr;
  logic [Q_BITS-1:0] q_full;

  assign q_full = {q_sr, q_bit};
  assign q_byte = (byte_idx < 4'(Q_BYTES))
                ? 8'(q_buf >> (7'(Q_BITS - 8) - {byte_idx, 3'b000})) : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_sr    <= '0;
      q_buf   <= '0;
      crc_ok  <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (data_stb) q_sr <= q_full[Q_BITS-2:0];
      if (blk_done) begin
        q_buf  <= q_full;
        crc_ok <= q_crc_good(q_full);
      end
      if (blk_done)   pending <= 1'b1;
      else if (q_clr) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/subq_rwfifo.sv
module subq_rwfifo import subq_pkg::*; #(
  parameter int DEPTH = 144
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart,
  input  logic                       stb,
  input  logic [5:0]                 rw_bits,
  input  logic                       pop,
  input  logic                       ovf_clr,
  output logic [7:0]                 dout,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       ovf,
  output logic                       push_fire,
  output logic                       pop_fire
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [5:0]    acc;
  logic [2:0]    held;
  logic [11:0]   joined;
  logic          emit, full, push_req;
  logic [7:0]    new_byte;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    joined    = {acc, rw_bits};
    emit      = held >= 3'd2;
    new_byte  = rw_take_byte(joined, held);
    full      = count == CW'(DEPTH);
    empty     = count == '0;
    push_req  = stb && emit;
    push_fire = push_req && !full;
    pop_fire  = pop && !empty;
    dout      = empty ? 8'h00 : mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= new_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      held   <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (restart) begin
        held <= '0;
      end else if (stb) begin
        acc  <= joined[5:0];
        held <= emit ? held - 3'd2 : held + 3'd6;
      end
      if (push_fire) wr_ptr <= ptr_next(wr_ptr);
      if (pop_fire)  rd_ptr <= ptr_next(rd_ptr);
      if (push_fire && !pop_fire)      count <= count + 1'b1;
      else if (pop_fire && !push_fire) count <= count - 1'b1;
      if (push_req && full) ovf <= 1'b1;
      else if (ovf_clr)     ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/subq_rw_extract.sv
module subq_rw_extract import subq_pkg::*; #(
  parameter int RW_DEPTH = 144
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sym_valid,
  input  logic [7:0]                    sym_data,
  input  logic                          sym_sync,
  input  logic [3:0]                    q_byte_idx,
  output logic [7:0]                    q_byte,
  output logic                          q_crc_ok,
  input  logic                          q_irq_en,
  output logic                          q_irq,
  input  logic                          q_clr,
  input  logic                          rw_pop,
  output logic [7:0]                    rw_data,
  output logic                          rw_empty,
  output logic [$clog2(RW_DEPTH+1)-1:0] rw_count,
  output logic                          rw_ovf,
  input  logic                          rw_ovf_clr,
  output logic                          sync_err,
  input  logic                          sync_err_clr
);
  logic              blk_start, data_stb, blk_done, over_run, sync_fault;
  logic              q_pending, push_fire, pop_fire;
  logic [Q_BITS-1:0] q_buf;
  logic              unused_pbit;

  assign unused_pbit = sym_data[7];

  subq_framer u_framer (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_sync(sym_sync),
    .blk_start(blk_start), .data_stb(data_stb), .blk_done(blk_done),
    .over_run(over_run), .sync_fault(sync_fault)
  );

  subq_qbuf u_qbuf (
    .clk(clk), .rst_n(rst_n), .data_stb(data_stb), .blk_done(blk_done),
    .q_bit(sym_data[6]), .q_clr(q_clr), .byte_idx(q_byte_idx),
    .q_buf(q_buf), .q_byte(q_byte), .crc_ok(q_crc_ok), .pending(q_pending)
  );

  subq_rwfifo #(.DEPTH(RW_DEPTH)) u_rw (
    .clk(clk), .rst_n(rst_n), .restart(blk_start), .stb(data_stb),
    .rw_bits(sym_data[5:0]), .pop(rw_pop), .ovf_clr(rw_ovf_clr),
    .dout(rw_data), .empty(rw_empty), .count(rw_count), .ovf(rw_ovf),
    .push_fire(push_fire), .pop_fire(pop_fire)
  );

  assign q_irq = q_pending && q_irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            sync_err <= 1'b0;
    else if (sync_fault)   sync_err <= 1'b1;
    else if (sync_err_clr) sync_err <= 1'b0;
  end
endmodule

// File: rtl/subq_rw_extract_chk.sv
module subq_rw_extract_chk #(
  parameter int RW_DEPTH = 144
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          data_stb,
  input logic                          blk_done,
  input logic                          over_run,
  input logic                          push_fire,
  input logic                          pop_fire,
  input logic                          q_pending,
  input logic                          q_clr,
  input logic [95:0]                   q_buf,
  input logic [$clog2(RW_DEPTH+1)-1:0] rw_count,
  input logic                          rw_ovf,
  input logic                          rw_ovf_clr,
  input logic                          sync_err
);
  localparam int CW = $clog2(RW_DEPTH + 1);

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rw_count <= CW'(RW_DEPTH));

  p_pop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !push_fire) |=> rw_count == $past(rw_count) - 1'b1);

  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_count == CW'(RW_DEPTH) && !pop_fire) |=> rw_count == CW'(RW_DEPTH));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_ovf && !rw_ovf_clr) |=> rw_ovf);

  p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pending && !q_clr) |=> q_pending);

  p_done_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> q_pending);

  p_qbuf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_done |=> $stable(q_buf));

  p_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    over_run |=> sync_err);

  p_push_in_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |-> data_stb);
endmodule

bind subq_rw_extract subq_rw_extract_chk #(.RW_DEPTH(RW_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_stb(data_stb), .blk_done(blk_done),
  .over_run(over_run), .push_fire(push_fire), .pop_fire(pop_fire),
  .q_pending(q_pending), .q_clr(q_clr), .q_buf(q_buf), .rw_count(rw_count),
  .rw_ovf(rw_ovf), .rw_ovf_clr(rw_ovf_clr), .sync_err(sync_err)
);

// File: tb/subq_rw_extract_tb.sv
module subq_rw_extract_tb;
  localparam int DEPTH = 144;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_valid = 1'b0, sym_sync = 1'b0;
  logic [7:0] sym_data = '0;
  logic [3:0] q_byte_idx = '0;
  logic [7:0] q_byte, rw_data;
  logic q_crc_ok, q_irq, rw_empty, rw_ovf, sync_err;
  logic q_irq_en = 1'b0, q_clr = 1'b0, rw_pop = 1'b0;
  logic rw_ovf_clr = 1'b0, sync_err_clr = 1'b0;
  logic [CW-1:0] rw_count;

  int errors = 0, checks = 0;
  logic [7:0] exp_q [0:1023];
  int ew = 0, er = 0;
  logic [95:0] last_q = '0;

  always #5 clk = ~clk;

  subq_rw_extract #(.RW_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_data(sym_data),
    .sym_sync(sym_sync), .q_byte_idx(q_byte_idx), .q_byte(q_byte),
    .q_crc_ok(q_crc_ok), .q_irq_en(q_irq_en), .q_irq(q_irq), .q_clr(q_clr),
    .rw_pop(rw_pop), .rw_data(rw_data), .rw_empty(rw_empty),
    .rw_count(rw_count), .rw_ovf(rw_ovf), .rw_ovf_clr(rw_ovf_clr),
    .sync_err(sync_err), .sync_err_clr(sync_err_clr)
  );

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [95:0] make_q(input logic [79:0] pl);
    logic [15:0] r = 16'h0000;
    for (int i = 0; i < 80; i++) begin
      logic top = r[15] ^ pl[79-i];
      r = (r << 1) ^ (top ? 16'h1021 : 16'h0000);
    end
    return {pl, ~r};
  endfunction

  task automatic model_push(input logic [7:0] b);
    if (ew - er < DEPTH) begin
      exp_q[ew % 1024] = b;
      ew++;
    end
  endtask

  task automatic send_sym(input logic [7:0] d, input logic s);
    @(negedge clk);
    sym_valid = 1'b1; sym_data = d; sym_sync = s;
    @(negedge clk);
    sym_valid = 1'b0; sym_sync = 1'b0;
  endtask

  task automatic send_block(input logic [95:0] q, input logic [7:0] seed,
                            input int ndata, input logic pfill);
    logic [23:0] grp = '0;
    send_sym(8'hC3, 1'b1);
    send_sym(8'h5A, 1'b0);
    for (int i = 0; i < ndata; i++) begin
      logic [5:0] rw = 6'(seed + 8'(i * 11));
      logic pb = pfill ^ i[0];
      grp = {grp[17:0], rw};
      send_sym({pb, q[95-i], rw}, 1'b0);
      if (i % 4 == 3) begin
        model_push(grp[23:16]); model_push(grp[15:8]); model_push(grp[7:0]);
      end
    end
    if (ndata == 96) last_q = q;
  endtask

  task automatic check_q(input string tag);
    for (int b = 0; b < 16; b++) begin
      logic [7:0] e = (b < 12) ? 8'(last_q >> (88 - 8 * b)) : 8'h00;
      @(negedge clk); q_byte_idx = 4'(b); #1;
      chk(q_byte == e, tag, {24'h0, q_byte}, {24'h0, e});
    end
  endtask

  task automatic drain(input string tag);
    while (er < ew) begin
      chk(!rw_empty && rw_data == exp_q[er % 1024], tag,
          {24'h0, rw_data}, {24'h0, exp_q[er % 1024]});
      er++;
      rw_pop = 1'b1;
      @(negedge clk);
    end
    rw_pop = 1'b0;
    chk(rw_empty, {tag, " empty after drain"}, {31'h0, rw_empty}, 32'h1);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1; @(negedge clk); sig = 1'b0;
  endtask

  task automatic t_reset;
    chk(!q_irq && !rw_ovf && !sync_err && !q_crc_ok, "R1 flags",
        {28'h0, q_irq, rw_ovf, sync_err, q_crc_ok}, 32'h0);
    chk(rw_empty && rw_count == 0, "R1 fifo", {24'h0, rw_count}, 32'h0);
    check_q("R1 q bytes zero");
  endtask

  task automatic t_presync;
    for (int i = 0; i < 6; i++) send_sym(8'h7F, 1'b0);
    chk(rw_count == 0, "R2 pre-sync ignored", {24'h0, rw_count}, 32'h0);
    chk(!q_irq, "R2 no pending", {31'h0, q_irq}, 32'h0);
  endtask

  task automatic t_good_block;
    q_irq_en = 1'b1;
    send_block(make_q(80'h41_01_02_00_10_22_00_03_14_55), 8'h05, 96, 1'b1);
    chk(q_irq, "R5 irq on block", {31'h0, q_irq}, 32'h1);
    chk(q_crc_ok, "R4 good crc", {31'h0, q_crc_ok}, 32'h1);
    chk(rw_count == 72, "R6 72 bytes", {24'h0, rw_count}, 32'd72);
    check_q("R3 R12 q bytes");
    drain("R6 R7 rw bytes");
    pulse(q_clr);
    chk(!q_irq, "R5 clear", {31'h0, q_irq}, 32'h0);
  endtask

  task automatic t_bad_crc;
    logic [95:0] q = make_q(80'h01_13_05_00_02_41_00_20_33_70) ^ 96'h1;
    send_block(q, 8'h21, 96, 1'b0);
    chk(!q_crc_ok, "R4 bad crc", {31'h0, q_crc_ok}, 32'h0);
    check_q("R3 q bytes bad block");
    q_irq_en = 1'b0; @(negedge clk);
    chk(!q_irq, "R5 masked", {31'h0, q_irq}, 32'h0);
    q_irq_en = 1'b1; @(negedge clk);
    chk(q_irq, "R5 not lost by mask", {31'h0, q_irq}, 32'h1);
    pulse(q_clr);
    drain("R7 second block");
  endtask

  task automatic t_early_sync;
    send_block(make_q(80'hFFEE_DDCC_BBAA_9988_7766), 8'h33, 40, 1'b1);
    send_sym(8'h00, 1'b1);
    chk(sync_err, "R9 early sync flag", {31'h0, sync_err}, 32'h1);
    chk(!q_irq, "R9 no pending", {31'h0, q_irq}, 32'h0);
    check_q("R9 q unchanged");
    send_block(make_q(80'h21_07_01_02_03_00_04_05_06_08), 8'h3F, 96, 1'b0);
    chk(q_crc_ok && q_irq, "R9 resync block", {30'h0, q_crc_ok, q_irq}, 32'h3);
    check_q("R9 q after resync");
    drain("R9 R6 rw partial and full");
    pulse(sync_err_clr);
    chk(!sync_err, "R11 clear", {31'h0, sync_err}, 32'h0);
    pulse(q_clr);
  endtask

  task automatic t_overlong;
    send_block(make_q(80'h11_22_33_44_55_66_77_88_99_AA), 8'h0C, 96, 1'b1);
    drain("R6 block before overrun");
    pulse(q_clr);
    send_sym(8'h3F, 1'b0);
    chk(sync_err, "R10 overrun flag", {31'h0, sync_err}, 32'h1);
    for (int i = 0; i < 12; i++) send_sym(8'h2A, 1'b0);
    chk(rw_empty, "R10 ignored rw", {24'h0, rw_count}, 32'h0);
    chk(!q_irq, "R10 ignored q", {31'h0, q_irq}, 32'h0);
    pulse(sync_err_clr);
    send_block(make_q(80'h05_04_03_02_01_00_0A_0B_0C_0D), 8'h17, 96, 1'b0);
    chk(q_irq && !sync_err, "R10 relock", {30'h0, q_irq, sync_err}, 32'h2);
    check_q("R10 q after relock");
    drain("R10 rw after relock");
    pulse(q_clr);
  endtask

  task automatic t_overflow;
    send_block(make_q(80'h01), 8'h01, 96, 1'b0);
    send_block(make_q(80'h02), 8'h2B, 96, 1'b1);
    chk(rw_count == DEPTH && !rw_ovf, "R8 full no ovf",
        {23'h0, rw_ovf, rw_count}, 32'(DEPTH));
    send_block(make_q(80'h03), 8'h15, 96, 1'b0);
    chk(rw_count == DEPTH, "R8 count held", {24'h0, rw_count}, 32'(DEPTH));
    chk(rw_ovf, "R8 ovf set", {31'h0, rw_ovf}, 32'h1);
    drain("R8 contents kept");
    chk(rw_ovf, "R8 ovf sticky", {31'h0, rw_ovf}, 32'h1);
    pulse(rw_ovf_clr);
    chk(!rw_ovf, "R8 ovf clear", {31'h0, rw_ovf}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_presync();
    t_good_block();
    t_bad_crc();
    t_early_sync();
    t_overlong();
    t_overflow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule